// File: doc/BRIEF.md
# Direct Segment Address Translator

This block turns data virtual addresses into physical addresses for a memory system where paging and a single large contiguous segment work side by side. Software loads a per-process segment with three values: the first virtual address of the segment, its exclusive end address, and a displacement. The displacement equals the segment's first virtual address minus its first physical address. Every incoming address is range-checked while the page translation result is presented on the TLB input. An address inside the segment is translated by subtracting the displacement and never depends on the TLB. An address outside the segment takes the TLB frame, or raises a miss request when the TLB has no entry.

Requests arrive on a valid/ready stream together with the TLB hit flag and frame number for the same address. Results leave one cycle later on a second valid/ready stream. A stalled response is held unchanged and blocks new requests: `req_ready` is high only while the output register is empty or is being drained in the same cycle. The segment registers sit behind a plain write/select/read port so that software can save and restore them on a context switch. A saturating counter records TLB misses that the segment absorbed, which gives a measure of how much the segment covers.

Top module: `dseg_xlate`

## Requirements
- R1: The three registers are selected by `reg_sel`: 0 for segment start, 1 for segment end, 2 for displacement. A register is written from `reg_wdata` at a clock edge where `reg_wr` is high. `reg_rdata` shows the selected register without delay. Selector 3 reads as zero and writes to it change nothing.
- R2: An address matches the segment when start <= va < end, compared as unsigned 47-bit values. When start >= end, no address matches. `rsp_seg` reports the match.
- R3: For a matching address, `rsp_pa` = va - displacement modulo 2^47. This holds whatever `tlb_hit` and `tlb_pfn` are.
- R4: For a non-matching address with `tlb_hit`=1, `rsp_pa` = {`tlb_pfn`, va[11:0]}, `rsp_seg`=0 and `rsp_miss`=0.
- R5: `rsp_miss`=1 only for a non-matching address with `tlb_hit`=0, and in that case `rsp_pa`=0. A matching address never raises `rsp_miss`.
- R6: A request accepted at a clock edge (`req_valid` and `req_ready` both high) shows its result with `rsp_valid`=1 right after that edge. `rsp_valid` rises only after an acceptance.
- R7: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, the response stays unchanged.
- R8: A register write at the same edge as an acceptance does not affect that request. Every request accepted afterwards uses the new value.
- R9: `miss_count` clears on reset. It rises by one for each accepted request that matches the segment while `tlb_hit`=0, and does not change for any other request.
- R10: `miss_count` saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_va | input | VA_W | Virtual address (47 significant bits) |
| tlb_hit | input | 1 | TLB holds a translation for req_va |
| tlb_pfn | input | VA_W-PG_W | Physical frame from the TLB |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | VA_W | Physical address |
| rsp_seg | output | 1 | Translated by the segment |
| rsp_miss | output | 1 | TLB miss request (page walk needed) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | VA_W | Register write data |
| reg_rdata | output | VA_W | Selected register value |
| miss_count | output | CNT_W | Saturating count of TLB misses covered by the segment |

## Verification
A corrupted segment register shows up at once on `reg_rdata` when it is selected. It shows up at the next accepted request as a wrong `rsp_seg` or a shifted `rsp_pa` one cycle later. A wrong match decision also shows in the same response as a spurious or missing `rsp_miss`, and in `miss_count` right after that edge. A broken hold path changes `rsp_pa` or drops `rsp_valid` in the first stalled cycle. The reference model compares all of these on every clock, including the cycle after each register write that coincides with an acceptance.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_DISP  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int NUM_REGS = 3;
endpackage

// File: rtl/dseg_regs.sv
module dseg_regs #(
  parameter int VA_W = 47
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      sel,
  input  logic [VA_W-1:0] wdata,
  output logic [VA_W-1:0] rdata,
  output logic [VA_W-1:0] seg_start,
  output logic [VA_W-1:0] seg_end,
  output logic [VA_W-1:0] seg_disp
);
  import dseg_pkg::*;

  logic [VA_W-1:0] q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= '0;
      else if (wr_en && (sel == 2'(i)))
        q[i] <= wdata;
    end
  end

  assign seg_start = q[0];
  assign seg_end   = q[1];
  assign seg_disp  = q[2];

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_START: rdata = q[0];
      SEL_END:   rdata = q[1];
      SEL_DISP:  rdata = q[2];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dseg_match.sv
module dseg_match #(
  parameter int VA_W = 47,
  parameter int PG_W = 12
) (
  input  logic [VA_W-1:0]      va,
  input  logic [VA_W-1:0]      seg_start,
  input  logic [VA_W-1:0]      seg_end,
  input  logic [VA_W-1:0]      seg_disp,
  input  logic                 tlb_hit,
  input  logic [VA_W-PG_W-1:0] tlb_pfn,
  output logic                 seg_hit,
  output logic                 miss_req,
  output logic [VA_W-1:0]      pa
);
  logic above_start, below_end;

  assign above_start = (va >= seg_start);
  assign below_end   = (va < seg_end);
  assign seg_hit     = above_start && below_end;
  assign miss_req    = !seg_hit && !tlb_hit;

  always_comb begin
    if (seg_hit)
      pa = va - seg_disp;
    else if (tlb_hit)
      pa = {tlb_pfn, va[PG_W-1:0]};
    else
      pa = '0;
  end
endmodule

// File: rtl/dseg_sat_ctr.sv
module dseg_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (inc && (count != MAX))
      count <= count + 1'b1;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAX) |=> (count == MAX));

  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate #(
  parameter int VA_W  = 47,
  parameter int PG_W  = 12,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 tlb_hit,
  input  logic [VA_W-PG_W-1:0] tlb_pfn,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [VA_W-1:0]      rsp_pa,
  output logic                 rsp_seg,
  output logic                 rsp_miss,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [VA_W-1:0]      reg_wdata,
  output logic [VA_W-1:0]      reg_rdata,
  output logic [CNT_W-1:0]     miss_count
);
  logic [VA_W-1:0] seg_start, seg_end, seg_disp;
  logic            hit_c, miss_c;
  logic [VA_W-1:0] pa_c;
  logic            accept;

  dseg_regs #(.VA_W(VA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .seg_start(seg_start), .seg_end(seg_end), .seg_disp(seg_disp)
  );

  dseg_match #(.VA_W(VA_W), .PG_W(PG_W)) u_match (
    .va(req_va), .seg_start(seg_start), .seg_end(seg_end), .seg_disp(seg_disp),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .seg_hit(hit_c), .miss_req(miss_c), .pa(pa_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_seg   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= pa_c;
      rsp_seg   <= hit_c;
      rsp_miss  <= miss_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  dseg_sat_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(accept && hit_c && !tlb_hit),
    .count(miss_count)
  );

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_seg) && $stable(rsp_miss)));

  // R6
  rise_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R5
  seg_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_seg && rsp_miss));
endmodule

// File: tb/dseg_xlate_test.sv
module dseg_xlate_test;
  localparam int VA_W = 47;
  localparam int PG_W = 12;
  localparam int CNT_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, tlb_hit = 1'b0, rsp_ready = 1'b0, reg_wr = 1'b0;
  logic [VA_W-1:0] req_va = '0, reg_wdata = '0;
  logic [VA_W-PG_W-1:0] tlb_pfn = '0;
  logic [1:0] reg_sel = 2'd0;
  logic req_ready, rsp_valid, rsp_seg, rsp_miss;
  logic [VA_W-1:0] rsp_pa, reg_rdata;
  logic [CNT_W-1:0] miss_count;

  always #5 clk = ~clk;

  dseg_xlate #(.VA_W(VA_W), .PG_W(PG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_seg(rsp_seg), .rsp_miss(rsp_miss), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .miss_count(miss_count)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string ctx = "reset";

  // reference model state
  logic [VA_W-1:0] m_reg [4];
  logic m_valid = 0, m_seg = 0, m_miss = 0;
  logic [VA_W-1:0] m_pa = '0;
  int m_cnt = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R6 rsp_valid", 64'(rsp_valid), 64'(m_valid));
    if (m_valid) begin
      chk("R2 rsp_seg", 64'(rsp_seg), 64'(m_seg));
      chk(m_seg ? "R3 rsp_pa" : (m_miss ? "R5 rsp_pa" : "R4 rsp_pa"), 64'(rsp_pa), 64'(m_pa));
      chk("R5 rsp_miss", 64'(rsp_miss), 64'(m_miss));
    end
    chk(m_cnt == CMAX ? "R10 miss_count" : "R9 miss_count", 64'(miss_count), 64'(m_cnt));
    chk("R1 reg_rdata", 64'(reg_rdata), 64'(m_reg[reg_sel]));
  endtask

  task automatic step(input bit v, input logic [VA_W-1:0] va, input bit hit,
                      input logic [VA_W-PG_W-1:0] pfn, input bit rdy,
                      input bit wr, input logic [1:0] sel, input logic [VA_W-1:0] wd);
    bit acc, s;
    compare_outputs();
    req_valid = v; req_va = va; tlb_hit = hit; tlb_pfn = pfn;
    rsp_ready = rdy; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #1;
    chk("R7 req_ready", 64'(req_ready), 64'(!m_valid || rdy));
    acc = v && (!m_valid || rdy);
    if (acc) begin
      s = (va >= m_reg[0]) && (va < m_reg[1]);
      m_seg = s;
      m_miss = !s && !hit;
      m_pa = s ? va - m_reg[2] : (hit ? {pfn, va[PG_W-1:0]} : '0);
      m_valid = 1;
      if (s && !hit && m_cnt < CMAX) m_cnt++;
    end else if (rdy) begin
      m_valid = 0;
    end
    if (wr && sel != 2'd3) m_reg[sel] = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [VA_W-1:0] d);
    step(0, '0, 0, '0, 1, 1, sel, d);
  endtask

  task automatic req(input logic [VA_W-1:0] va, input bit hit,
                     input logic [VA_W-PG_W-1:0] pfn, input bit rdy);
    step(1, va, hit, pfn, rdy, 0, 2'd0, '0);
  endtask

  task automatic idle(input bit rdy, input logic [1:0] sel);
    step(0, '0, 0, '0, rdy, 0, sel, '0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state: rsp_valid 0, count 0, registers 0 (R6, R9, R1)
    ctx = "reset R9";
    idle(1, 2'd0);

    // R1: load, read back, selector 3 ignored
    ctx = "R1 regs";
    wr_reg(2'd0, 47'h0000_1000_0000);
    wr_reg(2'd1, 47'h0000_2000_0000);
    wr_reg(2'd2, 47'h0000_0B00_0000);
    wr_reg(2'd3, 47'h7FFF_FFFF_FFFF);
    for (int s = 0; s < 4; s++) idle(1, 2'(s));

    // R2/R3: inside the segment, TLB miss and TLB hit both ignored
    ctx = "R3 inside";
    req(47'h0000_1000_0000, 0, 35'h1234, 1);
    req(47'h0000_1800_0ABC, 1, 35'h7777, 1);
    req(47'h0000_1FFF_FFFF, 0, 35'h0, 1);
    // R2 end is exclusive, below start misses
    ctx = "R2 edges";
    req(47'h0000_2000_0000, 1, 35'h0042, 1);
    req(47'h0000_0FFF_FFFF, 0, 35'h0042, 1);
    // R4 / R5 outside
    ctx = "R4 tlb";
    req(47'h0000_3000_0123, 1, 35'h5_5555, 1);
    ctx = "R5 miss";
    req(47'h0000_3000_0123, 0, 35'h5_5555, 1);
    idle(1, 2'd0);

    // R7 back-pressure: response held, requests blocked
    ctx = "R7 stall";
    req(47'h0000_1000_0040, 0, 35'h0, 0);
    req(47'h0000_4000_0000, 1, 35'h00AA, 0);
    req(47'h0000_4000_0000, 1, 35'h00AA, 0);
    req(47'h0000_4000_0000, 1, 35'h00AA, 1);
    req(47'h0000_1000_0080, 0, 35'h0, 1);
    idle(0, 2'd0);
    idle(1, 2'd0);

    // R8: write in the same cycle as an acceptance
    ctx = "R8 write";
    step(1, 47'h0000_1000_0100, 0, '0, 1, 1, 2'd2, 47'h0000_0000_0100);
    req(47'h0000_1000_0100, 0, '0, 1);
    step(1, 47'h0000_2000_0000, 0, '0, 1, 1, 2'd1, 47'h0000_3000_0000);
    req(47'h0000_2000_0000, 0, '0, 1);
    idle(1, 2'd2);

    // R3 modular wrap of the displacement
    ctx = "R3 wrap";
    wr_reg(2'd2, 47'h7FFF_FFFF_FF00);
    req(47'h0000_1000_0000, 0, '0, 1);

    // R2 start == end disables the segment
    ctx = "R2 disabled";
    wr_reg(2'd1, 47'h0000_1000_0000);
    req(47'h0000_1000_0000, 0, '0, 1);
    req(47'h0000_1000_0000, 1, 35'h0033, 1);
    wr_reg(2'd0, 47'h0000_2000_0000);
    req(47'h0000_1800_0000, 0, '0, 1);

    // R10 saturation
    ctx = "R10 sat";
    wr_reg(2'd0, 47'h0);
    wr_reg(2'd1, 47'h7FFF_FFFF_FFFF);
    for (int i = 0; i < 270; i++) req(47'(i * 64), 0, '0, 1);
    req(47'h100, 1, 35'h9, 1);
    idle(1, 2'd1);
    idle(1, 2'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule